// File: doc/BRIEF.md
# Page Bank Mapper

This block converts a 16-bit logical CPU address into a 21-bit physical address. The logical space is divided into eight 8 KB pages. Each page has its own 8-bit bank register. The three top address bits choose a register, and that register's bank number takes their place in front of the 13-bit offset. The result is a 2 MB physical space.

A register port serves the CPU's transfer instructions. A write copies the accumulator value into every bank register whose bit is set in a write mask. A read returns one register selected by a read mask. If several bits are set, the lowest-numbered page wins.

Reset clears every bank register to $00. Page 7 therefore maps bank 0, so the boot vectors at the top of logical memory are reachable. By convention, system software later maps bank $FF (I/O) and bank $F8 (work RAM) into low pages.

Top module: `page_bank_mapper`

## Requirements
- R1: While `rst_n` is low, and after it is released with no write, every bank register holds $00. `phys_addr` then equals `{8'h00, log_addr[12:0]}` for any address.
- R2: `log_addr[15:13]` selects the page register. Value 0 selects page 0 ($0000-$1FFF) and value 7 selects page 7 ($E000-$FFFF).
- R3: `phys_addr[20:13]` is the selected register's bank number. `phys_addr[12:0]` equals `log_addr[12:0]`.
- R4: At a rising clock edge, every page whose bit `i` of `wr_mask` is set loads `wr_data`. Several pages may load in the same edge.
- R5: A page whose `wr_mask` bit is clear keeps its value. An all-zero `wr_mask` changes nothing.
- R6: `rd_data` returns the register of the lowest-numbered page whose `rd_mask` bit is set.
- R7: An all-zero `rd_mask` gives `rd_data` = $00.
- R8: Translation and read-back are combinational. They follow `log_addr` and `rd_mask` without a clock edge.
- R9: A write becomes visible on `rd_data` and `phys_addr` only after the clock edge that performs it. In the cycle of the write, both outputs show the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_addr | input | 16 | Logical CPU address |
| phys_addr | output | 21 | Translated physical address |
| wr_mask | input | 8 | One bit per page register to load |
| wr_data | input | 8 | Bank number to load (accumulator value) |
| rd_mask | input | 8 | Page registers offered for read-back |
| rd_data | output | 8 | Bank number of lowest selected page |

## Verification
A register write and a translation or read-back through the same page can happen in one cycle. The bench provokes this with table rows that write a page while also reading it through `rd_mask`, and while addressing it through `log_addr`. Before the edge, the bench checks that both outputs still report the previous bank. The next row, sampled after the edge, must then show the new bank. This settles which value the pipeline exposes when the two meet.

// File: rtl/page_bank_mapper.sv
module page_bank_mapper #(
  parameter int PAGES  = 8,
  parameter int BANK_W = 8,
  parameter int LOG_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LOG_W-1:0]               log_addr,
  output logic [BANK_W+LOG_W-$clog2(PAGES)-1:0] phys_addr,
  input  logic [PAGES-1:0]               wr_mask,
  input  logic [BANK_W-1:0]              wr_data,
  input  logic [PAGES-1:0]               rd_mask,
  output logic [BANK_W-1:0]              rd_data
);
  localparam int SEL_W = $clog2(PAGES);
  localparam int OFF_W = LOG_W - SEL_W;

  logic [PAGES-1:0][BANK_W-1:0] map_q;
  logic [SEL_W-1:0]             page_sel;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          map_q[g] <= '0;
      else if (wr_mask[g]) map_q[g] <= wr_data;
    end

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask[g] |=> map_q[g] == $past(wr_data)); // R4
  end

  assign page_sel  = log_addr[LOG_W-1 -: SEL_W];
  assign phys_addr = {map_q[page_sel], log_addr[OFF_W-1:0]};

  always_comb begin
    rd_data = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (rd_mask[i]) rd_data = map_q[i];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> map_q == '0); // R1

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask == '0 |=> $stable(map_q)); // R5

  AST_READ_MATCHES_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mask == PAGES'(1) << page_sel |-> rd_data == phys_addr[OFF_W +: BANK_W]); // R6

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]); // R3
endmodule

// File: tb/test_page_bank_mapper.sv
module test_page_bank_mapper;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  wm;
    logic [7:0]  wd;
    logic [7:0]  rm;
    logic [15:0] la;
    logic [7:0]  exp_rd;
    logic [20:0] exp_pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'hFF, 8'h00, 16'h1234, 8'h00, 21'h001234},
    '{8'h02, 8'hF8, 8'h01, 16'h0ABC, 8'hFF, 21'h1FEABC},
    '{8'hFC, 8'h3C, 8'h02, 16'h2001, 8'hF8, 21'h1F0001},
    '{8'h00, 8'hAA, 8'hFC, 16'hFFFF, 8'h3C, 21'h079FFF},
    '{8'h80, 8'h00, 8'h80, 16'hE000, 8'h3C, 21'h078000},
    '{8'h00, 8'h00, 8'h80, 16'hFFFE, 8'h00, 21'h001FFE},
    '{8'h10, 8'h7F, 8'h10, 16'h8123, 8'h3C, 21'h078123},
    '{8'h00, 8'h00, 8'h18, 16'h9FFF, 8'h3C, 21'h0FFFFF},
    '{8'h00, 8'h00, 8'h00, 16'h6000, 8'h00, 21'h078000},
    '{8'h00, 8'h00, 8'h20, 16'hA5A5, 8'h3C, 21'h0785A5}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] log_addr = '0;
  logic [20:0] phys_addr;
  logic [7:0]  wr_mask = '0, wr_data = '0, rd_mask = '0, rd_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_bank_mapper i_page_bank_mapper (
    .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .phys_addr(phys_addr),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_mask(rd_mask), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: every page is bank 0 after reset
    for (int p = 0; p < 8; p++) begin
      rd_mask = 8'(1 << p);
      #1 check("R1 reset read", 32'(rd_data), 32'h00);
    end
    log_addr = 16'hFFFC;
    #1 check("R1 reset xlate", 32'(phys_addr), 32'h001FFC);

    // R2 R3 R4 R5 R6 R7 R9: table walk, sampled before each edge
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_mask = VECS[v].wm; wr_data = VECS[v].wd;
      rd_mask = VECS[v].rm; log_addr = VECS[v].la;
      #1;
      check("R6 R7 R9 rd_data", 32'(rd_data), 32'(VECS[v].exp_rd));
      check("R2 R3 R9 phys_addr", 32'(phys_addr), 32'(VECS[v].exp_pa));
    end
    @(negedge clk);
    wr_mask = '0;

    // R8: combinational response without a clock edge (page4=7F, page0=FF)
    log_addr = 16'h8004; rd_mask = 8'h01;
    #1 check("R8 xlate", 32'(phys_addr), 32'h0FE004);
    check("R8 read", 32'(rd_data), 32'hFF);
    log_addr = 16'h2010; rd_mask = 8'h02;
    #1 check("R8 xlate change", 32'(phys_addr), 32'h1F0010);
    check("R8 read change", 32'(rd_data), 32'hF8);

    // R7: all-zero mask reads zero even with nonzero registers
    rd_mask = 8'h00;
    #1 check("R7 zero mask", 32'(rd_data), 32'h00);

    // R4: write all pages at once, then R6 lowest of full mask
    @(negedge clk);
    wr_mask = 8'hFF; wr_data = 8'h5A;
    @(negedge clk);
    wr_mask = 8'h00; rd_mask = 8'hFF; log_addr = 16'hC001;
    #1 check("R4 all pages", 32'(rd_data), 32'h5A);
    check("R4 all pages xlate", 32'(phys_addr), 32'h0B4001);

    // R1: reset mid-run clears everything
    rst_n = 0;
    #1 check("R1 async clear", 32'(rd_data), 32'h00);
    check("R1 async xlate", 32'(phys_addr), 32'h000001);
    @(negedge clk);
    rst_n = 1;
    rd_mask = 8'h80; log_addr = 16'hFFFE;
    #1 check("R1 page7 bank0", 32'(phys_addr), 32'h001FFE);
    check("R1 page7 read", 32'(rd_data), 32'h00);

    finish_run();
  end
endmodule